// File: doc/BRIEF.md
# SPI Master with Mode-Fault Detection

This block is a single-channel serial peripheral master for full-duplex, byte-style exchanges. Software enables master operation and then writes a word into the transmit buffer. That write starts the exchange at once. The block drives the serial clock and pulls its one select output low. It shifts the word out most significant bit first and, on the same clock, shifts the incoming line into the bottom of the same register. When the last bit has moved, the received word goes to a read buffer and a sticky completion flag is raised. The completion flag drives an interrupt request when the interrupt is enabled.

The serial clock idles low. Data changes on its falling edge and is sampled on its rising edge. A two-bit divider setting gives a serial clock of one half, one quarter, one eighth or one sixteenth of the system clock. A write that arrives while an exchange is running is dropped and recorded in a sticky collision flag.

Another master may share the bus. For that case, the external select input can be enabled as a collision detector. If that input goes low while the block is master, the block abandons the exchange, stops driving its clock and data pins, drops master mode and latches a sticky fault flag. When the detector is disabled, the select input has no effect.

Top module: `spi_host_mf`

## Requirements
- R1: After reset, `master_en`, `busy`, `done_flag`, `wcol_flag`, `fault_flag` and `irq` are 0, `sck` is 0, `ss_n_out` is 1, both output enables are 0 and `rd_data` is 0.
- R2: A `wr_en` pulse while `master_en` is 1 and `busy` is 0 starts an exchange. One clock later, `busy` is 1, `ss_n_out` is 0 and `mosi` carries bit W-1 of `wr_data`.
- R3: A `wr_en` pulse while `master_en` is 0 is ignored. `busy`, `ss_n_out` and `wcol_flag` stay unchanged.
- R4: `mosi` sends the word from bit W-1 down to bit 0 and changes only while `sck` is low. `miso` is sampled on each rising `sck` and shifted in at bit 0. After W bits, `rd_data` holds the received word, first-sampled bit in bit W-1.
- R5: Each `sck` half period is 2^`ctl_div_sel` clocks (select 0..3 gives a divide by 2, 4, 8 or 16). `busy` stays high for exactly 2·W·2^`ctl_div_sel` clocks. `sck` is 0 whenever `busy` is 0.
- R6: `done_flag` rises in the cycle the exchange ends. It stays set until a `clr_done` pulse, and a set in the same cycle as a clear wins.
- R7: `irq` is 1 exactly when `done_flag` is 1 and `ctl_irq_en` is 1.
- R8: A `wr_en` pulse while `busy` is 1 leaves the running exchange unchanged and sets `wcol_flag`. That flag stays set until `clr_wcol`.
- R9: With `ctl_fault_en` at 1 and `master_en` at 1, a low `ss_n_in` (seen after the synchronizer stages) causes all of the following: the exchange is aborted, `busy` and `master_en` drop, `sck_oe` and `mosi_oe` go to 0, and `fault_flag` is set until `clr_fault`. In this case `done_flag` is not set and `rd_data` keeps its old value.
- R10: With `ctl_fault_en` at 0, `ss_n_in` has no effect. An exchange with `ss_n_in` held low completes normally.
- R11: `ctl_master_set` sets `master_en` and `ctl_master_clr` clears it, aborting any exchange. `sck_oe` and `mosi_oe` follow `master_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_master_set | input | 1 | Pulse: enter master mode |
| ctl_master_clr | input | 1 | Pulse: leave master mode, abort exchange |
| ctl_div_sel | input | SEL_W | Serial clock divider select (half period 2^sel clocks) |
| ctl_irq_en | input | 1 | Interrupt enable for completion |
| ctl_fault_en | input | 1 | Enable select-input collision detection |
| wr_en | input | 1 | Pulse: write transmit buffer |
| wr_data | input | W | Word to transmit |
| clr_done | input | 1 | Pulse: clear completion flag |
| clr_wcol | input | 1 | Pulse: clear write-collision flag |
| clr_fault | input | 1 | Pulse: clear fault flag |
| miso | input | 1 | Serial data from slave |
| ss_n_in | input | 1 | External select, active low, watched for faults |
| sck | output | 1 | Serial clock, idles low |
| sck_oe | output | 1 | Output enable for sck |
| mosi | output | 1 | Serial data to slave |
| mosi_oe | output | 1 | Output enable for mosi |
| ss_n_out | output | 1 | Select to the slave, low during an exchange |
| rd_data | output | W | Last received word |
| master_en | output | 1 | Master mode active |
| busy | output | 1 | Exchange in progress |
| done_flag | output | 1 | Sticky completion flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| fault_flag | output | 1 | Sticky mode-fault flag |
| irq | output | 1 | Interrupt request |

## Verification
Exchanges run at all four divider settings with contrasting word pairs: alternating bits, all ones against all zeros, and a single set bit at opposite ends. Together these catch a reversed bit order, an off-by-one shift, or a sample taken on the wrong clock edge. Counting busy and high-clock cycles at each setting separates a correct divider from one that is off by a factor or a cycle. A second write during a busy exchange, a select pulled low with the detector on and then off, and a write with master mode off together show which inputs may change state and which must be ignored.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } xfer_state_t;

   // Largest half period for a divider select of a given width.
   function automatic int max_half(input int sel_w);
      return 1 << ((1 << sel_w) - 1);
   endfunction

endpackage

// File: rtl/spi_mf_divider.sv
module spi_mf_divider #(
   parameter int SEL_W = 2,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;

   assign half_m1 = CNT_W'((1 << sel) - 1);
   // Greater-or-equal so a lowered select mid-count cannot stall the clock.
   assign tick    = run && (cnt_q >= half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spi_mf_shift.sv
module spi_mf_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         rise,
   input  logic         fall,
   input  logic         miso,
   output logic         msb,
   output logic         last,
   output logic [W-1:0] rx_word
);

   localparam int BCW = (W > 1) ? $clog2(W) : 1;
   localparam logic [BCW-1:0] LAST_IDX = BCW'(W - 1);

   logic [W-1:0]   shreg_q;
   logic           sample_q;
   logic [BCW-1:0] bitcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         sample_q <= 1'b0;
         bitcnt_q <= '0;
      end else begin
         if (load) begin
            shreg_q  <= load_data;
            bitcnt_q <= '0;
         end else if (fall) begin
            shreg_q  <= {shreg_q[W-2:0], sample_q};
            bitcnt_q <= bitcnt_q + 1'b1;
         end
         if (rise) begin
            sample_q <= miso;
         end
      end
   end

   assign msb     = shreg_q[W-1];
   assign last    = (bitcnt_q == LAST_IDX);
   assign rx_word = {shreg_q[W-2:0], sample_q};

endmodule

// File: rtl/spi_mf_ss_sync.sv
module spi_mf_ss_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ss_n_async,
   output logic ss_n_sync
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign ss_n_sync = ss_n_async;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  chain_q[i] <= 1'b1;
               end else if (i == 0) begin
                  chain_q[i] <= ss_n_async;
               end else begin
                  chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
               end
            end
         end
         assign ss_n_sync = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_host_mf.sv
module spi_host_mf
   import spi_mf_pkg::*;
#(
   parameter int W           = 8,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_master_set,
   input  logic             ctl_master_clr,
   input  logic [SEL_W-1:0] ctl_div_sel,
   input  logic             ctl_irq_en,
   input  logic             ctl_fault_en,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             clr_done,
   input  logic             clr_wcol,
   input  logic             clr_fault,
   input  logic             miso,
   input  logic             ss_n_in,
   output logic             sck,
   output logic             sck_oe,
   output logic             mosi,
   output logic             mosi_oe,
   output logic             ss_n_out,
   output logic [W-1:0]     rd_data,
   output logic             master_en,
   output logic             busy,
   output logic             done_flag,
   output logic             wcol_flag,
   output logic             fault_flag,
   output logic             irq
);

   localparam int MAX_HALF = max_half(SEL_W);
   localparam int CNT_W    = $clog2(MAX_HALF) + 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("spi_host_mf: W must be at least 2");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("spi_host_mf: SEL_W must be 1..3");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("spi_host_mf: SYNC_STAGES must be 0..3");
      end
   endgenerate

   xfer_state_t state_q, state_nxt;
   logic        master_q;
   logic        sck_q;
   logic        ss_q;
   logic [W-1:0] rd_q;
   logic        done_q, wcol_q, fault_q;

   logic        ss_n_sync;
   logic        fault_hit;
   logic        abort_req;
   logic        start;
   logic        tick;
   logic        rise, fall, finish;
   logic        sh_msb, sh_last;
   logic [W-1:0] sh_rx;

   // Select-input synchronizer
   spi_mf_ss_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .ss_n_async (ss_n_in),
      .ss_n_sync  (ss_n_sync)
   );

   assign fault_hit = ctl_fault_en && master_q && !ss_n_sync;
   assign abort_req = fault_hit || ctl_master_clr;
   assign start     = wr_en && master_q && (state_q == ST_IDLE) && !abort_req;

   // Serial clock phase timer
   spi_mf_divider #(
      .SEL_W (SEL_W),
      .CNT_W (CNT_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q != ST_IDLE),
      .sel   (ctl_div_sel),
      .tick  (tick)
   );

   assign rise   = (state_q == ST_LOW)  && tick && !abort_req;
   assign fall   = (state_q == ST_HIGH) && tick && !abort_req;
   assign finish = fall && sh_last;

   // Shared transmit/receive shift register
   spi_mf_shift #(
      .W (W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .load_data (wr_data),
      .rise      (rise),
      .fall      (fall),
      .miso      (miso),
      .msb       (sh_msb),
      .last      (sh_last),
      .rx_word   (sh_rx)
   );

   // Exchange sequencer
   always_comb begin
      state_nxt = state_q;
      if (abort_req) begin
         state_nxt = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (start) state_nxt = ST_LOW;
            ST_LOW:  if (tick)  state_nxt = ST_HIGH;
            ST_HIGH: if (tick)  state_nxt = sh_last ? ST_IDLE : ST_LOW;
            default:            state_nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sck_q   <= 1'b0;
         ss_q    <= 1'b1;
      end else begin
         state_q <= state_nxt;
         sck_q   <= (state_nxt == ST_HIGH);
         ss_q    <= (state_nxt == ST_IDLE);
      end
   end

   // Mode and sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         fault_q  <= 1'b0;
         done_q   <= 1'b0;
         wcol_q   <= 1'b0;
         rd_q     <= '0;
      end else begin
         if (abort_req) begin
            master_q <= 1'b0;
         end else if (ctl_master_set) begin
            master_q <= 1'b1;
         end

         if (fault_hit) begin
            fault_q <= 1'b1;
         end else if (clr_fault) begin
            fault_q <= 1'b0;
         end

         if (finish) begin
            done_q <= 1'b1;
            rd_q   <= sh_rx;
         end else if (clr_done) begin
            done_q <= 1'b0;
         end

         if (wr_en && (state_q != ST_IDLE)) begin
            wcol_q <= 1'b1;
         end else if (clr_wcol) begin
            wcol_q <= 1'b0;
         end
      end
   end

   assign sck        = sck_q;
   assign sck_oe     = master_q;
   assign mosi       = (state_q != ST_IDLE) && sh_msb;
   assign mosi_oe    = master_q;
   assign ss_n_out   = ss_q;
   assign rd_data    = rd_q;
   assign master_en  = master_q;
   assign busy       = (state_q != ST_IDLE);
   assign done_flag  = done_q;
   assign wcol_flag  = wcol_q;
   assign fault_flag = fault_q;
   assign irq        = done_q && ctl_irq_en;

endmodule

// File: rtl/spi_mf_checker.sv
module spi_mf_checker (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic master_en,
   input logic busy,
   input logic ss_n_out,
   input logic sck,
   input logic sck_oe,
   input logic mosi,
   input logic mosi_oe,
   input logic done_flag,
   input logic wcol_flag,
   input logic fault_flag,
   input logic irq,
   input logic irq_en,
   input logic fault_hit,
   input logic abort_req
);

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && master_en && !busy && !abort_req |=> busy && !ss_n_out);

   assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && sck && $past(busy) && $past(sck) |-> $stable(mosi));

   assert_idle_sck_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(busy) && !busy);

   assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) && irq_en |-> irq);

   assert_wcol_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_en |=> wcol_flag);

   assert_fault_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_hit |=> !master_en && fault_flag && !busy && !sck && !sck_oe && !mosi_oe);

endmodule

bind spi_host_mf spi_mf_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .master_en  (master_en),
   .busy       (busy),
   .ss_n_out   (ss_n_out),
   .sck        (sck),
   .sck_oe     (sck_oe),
   .mosi       (mosi),
   .mosi_oe    (mosi_oe),
   .done_flag  (done_flag),
   .wcol_flag  (wcol_flag),
   .fault_flag (fault_flag),
   .irq        (irq),
   .irq_en     (ctl_irq_en),
   .fault_hit  (fault_hit),
   .abort_req  (abort_req)
);

// File: tb/spi_host_mf_test.sv
`timescale 1ns/1ps
module spi_host_mf_test;

   localparam int W = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_master_set = 0, ctl_master_clr = 0;
   logic [1:0] ctl_div_sel = 0;
   logic       ctl_irq_en = 0, ctl_fault_en = 0;
   logic       wr_en = 0;
   logic [W-1:0] wr_data = 0;
   logic       clr_done = 0, clr_wcol = 0, clr_fault = 0;
   logic       miso = 0;
   logic       ss_n_in = 1;
   logic       sck, sck_oe, mosi, mosi_oe, ss_n_out;
   logic [W-1:0] rd_data;
   logic       master_en, busy, done_flag, wcol_flag, fault_flag, irq;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   logic [W-1:0] slave_tx;
   logic [W-1:0] slave_rx;

   always #10 clk = ~clk;

   spi_host_mf uut (
      .clk(clk), .rst_n(rst_n),
      .ctl_master_set(ctl_master_set), .ctl_master_clr(ctl_master_clr),
      .ctl_div_sel(ctl_div_sel), .ctl_irq_en(ctl_irq_en), .ctl_fault_en(ctl_fault_en),
      .wr_en(wr_en), .wr_data(wr_data),
      .clr_done(clr_done), .clr_wcol(clr_wcol), .clr_fault(clr_fault),
      .miso(miso), .ss_n_in(ss_n_in),
      .sck(sck), .sck_oe(sck_oe), .mosi(mosi), .mosi_oe(mosi_oe), .ss_n_out(ss_n_out),
      .rd_data(rd_data), .master_en(master_en), .busy(busy),
      .done_flag(done_flag), .wcol_flag(wcol_flag), .fault_flag(fault_flag), .irq(irq)
   );

   // Mode-0 slave model: presents next bit after each falling edge, samples on rising edge.
   always @(negedge sck) begin
      slave_tx = {slave_tx[W-2:0], 1'b0};
      miso = slave_tx[W-1];
   end
   always @(posedge sck) begin
      slave_rx = {slave_rx[W-2:0], mosi};
   end

   task automatic slave_load(input logic [W-1:0] v);
      slave_tx = v;
      slave_rx = '0;
      miso = v[W-1];
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_master_set();
      ctl_master_set = 1; step(1); ctl_master_set = 0;
   endtask
   task automatic pulse_master_clr();
      ctl_master_clr = 1; step(1); ctl_master_clr = 0;
   endtask
   task automatic pulse_clr_done();
      clr_done = 1; step(1); clr_done = 0;
   endtask
   task automatic pulse_write(input logic [W-1:0] d);
      wr_data = d; wr_en = 1; step(1); wr_en = 0;
   endtask

   // Runs a full exchange and checks start, timing, data and flags.
   task automatic t_xfer(input logic [1:0] sel, input logic [W-1:0] tx,
                         input logic [W-1:0] rx, input bit ien);
      int half, bcnt, hcnt, guard;
      half = 1 << sel;
      ctl_div_sel = sel;
      ctl_irq_en = ien;
      slave_load(rx);
      pulse_write(tx);
      check(busy == 1 && ss_n_out == 0, "R2 start busy/select", {busy, ss_n_out}, 2'b10);
      check(mosi == tx[W-1], "R2 first bit is MSB", mosi, tx[W-1]);
      bcnt = 1; hcnt = 0; guard = 0;
      while (busy && guard < 2000) begin
         step(1);
         guard++;
         if (busy) bcnt++;
         if (sck) hcnt++;
      end
      check(bcnt == 2 * W * half, "R5 busy length", bcnt, 2 * W * half);
      check(hcnt == W * half, "R5 sck high cycles", hcnt, W * half);
      check(sck == 0 && ss_n_out == 1, "R5 idle sck low, select released", {sck, ss_n_out}, 2'b01);
      check(rd_data == rx, "R4 received word", rd_data, rx);
      check(slave_rx == tx, "R4 transmitted word MSB first", slave_rx, tx);
      check(done_flag == 1, "R6 done set at end", done_flag, 1);
      check(irq == ien, "R7 irq vs enable", irq, ien);
   endtask

   task automatic t_reset();
      check(master_en == 0 && busy == 0 && done_flag == 0 && wcol_flag == 0 &&
            fault_flag == 0 && irq == 0, "R1 flags clear",
            {master_en, busy, done_flag, wcol_flag, fault_flag, irq}, 0);
      check(sck == 0 && ss_n_out == 1 && sck_oe == 0 && mosi_oe == 0,
            "R1 pins idle", {sck, ss_n_out, sck_oe, mosi_oe}, 4'b0100);
      check(rd_data == 0, "R1 rd_data", rd_data, 0);
   endtask

   task automatic t_not_master();
      pulse_write(8'hC3);
      check(busy == 0 && ss_n_out == 1 && wcol_flag == 0, "R3 write ignored without master",
            {busy, ss_n_out, wcol_flag}, 3'b010);
   endtask

   task automatic t_master_ctl();
      pulse_master_set();
      check(master_en == 1 && sck_oe == 1 && mosi_oe == 1, "R11 master set enables pins",
            {master_en, sck_oe, mosi_oe}, 3'b111);
      ctl_div_sel = 2'd2;
      slave_load(8'h00);
      pulse_write(8'hF0);
      step(5);
      pulse_master_clr();
      check(master_en == 0 && busy == 0 && sck_oe == 0, "R11 master clear aborts",
            {master_en, busy, sck_oe}, 3'b000);
      pulse_master_set();
   endtask

   task automatic t_done_sticky();
      step(20);
      check(done_flag == 1, "R6 done holds", done_flag, 1);
      ctl_irq_en = 1;
      step(1);
      check(irq == 1, "R7 irq follows enable", irq, 1);
      ctl_irq_en = 0;
      step(1);
      check(irq == 0, "R7 irq masked", irq, 0);
      pulse_clr_done();
      check(done_flag == 0, "R6 done cleared", done_flag, 0);
   endtask

   task automatic t_wcol();
      int guard;
      ctl_div_sel = 2'd1;
      slave_load(8'h96);
      pulse_write(8'h3C);
      step(6);
      pulse_write(8'h00);
      check(wcol_flag == 1 && busy == 1, "R8 collision flagged, exchange continues",
            {wcol_flag, busy}, 2'b11);
      guard = 0;
      while (busy && guard < 500) begin step(1); guard++; end
      check(rd_data == 8'h96 && slave_rx == 8'h3C, "R8 exchange unaffected",
            {rd_data, slave_rx}, {8'h96, 8'h3C});
      step(5);
      check(wcol_flag == 1, "R8 collision sticky", wcol_flag, 1);
      clr_wcol = 1; step(1); clr_wcol = 0;
      check(wcol_flag == 0, "R8 collision cleared", wcol_flag, 0);
   endtask

   task automatic t_fault();
      logic [W-1:0] prev;
      prev = rd_data;
      pulse_clr_done();
      ctl_fault_en = 1;
      ctl_div_sel = 2'd3;
      slave_load(8'h55);
      pulse_write(8'hAA);
      step(10);
      ss_n_in = 0;
      step(5);
      check(busy == 0 && master_en == 0 && sck_oe == 0 && mosi_oe == 0,
            "R9 abort and release", {busy, master_en, sck_oe, mosi_oe}, 0);
      check(fault_flag == 1, "R9 fault set", fault_flag, 1);
      check(done_flag == 0 && rd_data == prev, "R9 no completion",
            {done_flag, rd_data}, {1'b0, prev});
      ss_n_in = 1;
      step(4);
      check(fault_flag == 1, "R9 fault sticky", fault_flag, 1);
      clr_fault = 1; step(1); clr_fault = 0;
      check(fault_flag == 0, "R9 fault cleared", fault_flag, 0);
      ctl_fault_en = 0;
   endtask

   task automatic t_fault_off();
      pulse_master_set();
      pulse_clr_done();
      ss_n_in = 0;
      step(4);
      t_xfer(2'd0, 8'h6E, 8'hB1, 1'b0);
      check(master_en == 1 && fault_flag == 0, "R10 select ignored when detector off",
            {master_en, fault_flag}, 2'b10);
      ss_n_in = 1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      slave_load('0);
      step(3);
      t_reset();
      rst_n = 1;
      step(2);
      t_reset();
      t_not_master();
      t_master_ctl();
      t_xfer(2'd0, 8'hA5, 8'h3C, 1'b1);
      t_done_sticky();
      t_xfer(2'd1, 8'hFF, 8'h00, 1'b0);
      pulse_clr_done();
      t_xfer(2'd2, 8'h01, 8'h80, 1'b1);
      pulse_clr_done();
      t_xfer(2'd3, 8'h5A, 8'hC7, 1'b0);
      t_wcol();
      t_fault();
      t_fault_off();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule